// File: doc/BRIEF.md
# Width-Switchable CPU Register File

This block holds the programmer-visible state of a 16-bit processor core: two accumulators, two index registers, a stack pointer, a program counter, a direct-page register, two 8-bit bank registers and a 16-bit status word. Two flags in the status word set the working width at run time. One flag sets the width of both accumulators and the other sets the width of both index registers. In narrow (8-bit) mode a write touches only the low byte, and a read returns zero in the high byte.

The surrounding core loads registers through one general write port. It updates the status word through a separate port. It reads any two registers at once through two registered read ports. The block also forms two kinds of address, each registered. The first is an indexed effective address: a 24-bit base plus X or Y, where the index is zero-extended from its low byte in narrow index mode. The second is the pair of 24-bit block-move addresses: a source bank byte joined with X, and a destination bank byte joined with Y. Every output appears one clock after the inputs and state it is computed from.

Top module: `mode_regfile`

## Requirements
- R1: After a synchronous reset every register reads 0, except the status word, which reads 0x0034 (I, x and m set, priority level 0). The read and address outputs read 0.
- R2: Reading A (select 0) or B (select 1) while the m flag (status bit 5) is 1 returns the low byte with bits 15:8 zero. While m is 0 the read returns all 16 bits.
- R3: A general write to A or B while m is 1 replaces only bits 7:0 and leaves bits 15:8 as they were. While m is 0 the write replaces all 16 bits.
- R4: X (select 2) and Y (select 3) follow the x flag (status bit 4) in the same way: 16-bit reads and writes when x is 0, low byte only when x is 1.
- R5: A status update that takes x from 0 to 1 clears bits 15:8 of both X and Y. A change of m alters neither accumulator.
- R6: The status word (select 9) holds C, Z, I, D, x, m, V, N in bits 0 to 7 and the priority level in bits 10:8. Bits 15:11 always read 0, whatever is written. General writes with select 9 leave the status word unchanged, and the status word holds its value when no status update is made.
- R7: The effective address equals the 24-bit base plus X (`idx_use_y`=0) or Y (`idx_use_y`=1), modulo 2^24. When x is 1 the index is only its low byte.
- R8: The block-move source address is the source bank byte in bits 23:16 and X in bits 15:0, with X masked to its low byte when x is 1.
- R9: The block-move destination address is the destination bank byte in bits 23:16 and Y in bits 15:0, with Y masked to its low byte when x is 1.
- R10: S (select 4), PC (select 5) and the direct-page register (select 6) are written and read at 16 bits. The program bank (select 7) and data bank (select 8) take bits 7:0 of a write and read with bits 15:8 zero.
- R11: All outputs are registered and reflect the state before the edge at which they are captured. When a general write to X or Y falls in the same cycle as an x rise, the register ends up as zero in bits 15:8 and the written low byte in bits 7:0. A write to A or B in the same cycle as an m change uses the old value of m.
- R12: Selects 10 to 15 read as 0, and a general write with any of them changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | General register write enable |
| wr_sel | input | 4 | Register written (0 A, 1 B, 2 X, 3 Y, 4 S, 5 PC, 6 DPR, 7 PB, 8 DB) |
| wr_data | input | 16 | Write data |
| st_wr_en | input | 1 | Status word update enable |
| st_wr_data | input | 16 | New status word (bits 15:11 dropped) |
| rd_sel_a | input | 4 | Register read on port A (9 = status) |
| rd_sel_b | input | 4 | Register read on port B |
| rd_data_a | output | 16 | Width-masked read data, port A |
| rd_data_b | output | 16 | Width-masked read data, port B |
| idx_use_y | input | 1 | Index register for the effective address: 0 X, 1 Y |
| idx_base | input | 24 | Base address for indexed addressing |
| ea_out | output | 24 | Registered effective address |
| src_bank | input | 8 | Source bank byte of a block move |
| dst_bank | input | 8 | Destination bank byte of a block move |
| blk_src | output | 24 | Block-move source address |
| blk_dst | output | 24 | Block-move destination address |

## Verification
Two operations can collide in one cycle. A general write to an index register can coincide with a status update that raises x. A write to an accumulator can coincide with a status update that flips m. A directed step provokes the X-write-plus-x-rise case and then reads X back at full width, expecting a cleared high byte. A long random phase issues status updates and register writes together many times. The behavioural model settles these cases by the stated priority: the write width comes from the old flag, and the clear wins over the high byte. It compares all five outputs against the model after every edge.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
  typedef enum logic [3:0] {
    SEL_A  = 4'd0,
    SEL_B  = 4'd1,
    SEL_X  = 4'd2,
    SEL_Y  = 4'd3,
    SEL_SP = 4'd4,
    SEL_PC = 4'd5,
    SEL_DP = 4'd6,
    SEL_PB = 4'd7,
    SEL_DB = 4'd8,
    SEL_ST = 4'd9
  } reg_sel_e;

  localparam int FLAG_I  = 2;
  localparam int FLAG_X  = 4;
  localparam int FLAG_M  = 5;
  localparam int LVL_LSB = 8;
endpackage

// File: rtl/mrf_wide_reg.sv
module mrf_wide_reg #(
  parameter int W         = 16,
  parameter int HALF      = 8,
  parameter bit CAN_CLEAR = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic         narrow,
  input  logic         clr_hi,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      if (we) begin
        q[HALF-1:0] <= d[HALF-1:0];
        if (!narrow) q[W-1:HALF] <= d[W-1:HALF];
      end
      if (CAN_CLEAR && clr_hi) q[W-1:HALF] <= '0;
    end
  end

  // R3 / R4: a narrow write keeps the high byte
  a_r3_hi_hold: assert property (@(posedge clk) disable iff (rst)
    (we && narrow && !clr_hi) |=> (q[W-1:HALF] == $past(q[W-1:HALF])));

  if (CAN_CLEAR) begin : g_clr
    a_r5_clear_hi: assert property (@(posedge clk) disable iff (rst)
      clr_hi |=> (q[W-1:HALF] == '0));
  end
endmodule

// File: rtl/mrf_status.sv
module mrf_status #(
  parameter int W     = 16,
  parameter int LVL_W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         m_flag,
  output logic         x_flag,
  output logic         x_rise
);
  import mrf_pkg::*;
  localparam int TOP = LVL_LSB + LVL_W;
  localparam logic [W-1:0] KEEP    = W'((1 << TOP) - 1);
  localparam logic [W-1:0] RST_VAL = W'((1 << FLAG_I) | (1 << FLAG_X) | (1 << FLAG_M));

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else if (we) q <= d & KEEP;
  end

  assign m_flag = q[FLAG_M];
  assign x_flag = q[FLAG_X];
  assign x_rise = we && !q[FLAG_X] && d[FLAG_X];

  // R6: without an update the status word holds
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/mrf_addr_gen.sv
module mrf_addr_gen #(
  parameter int W      = 16,
  parameter int HALF   = 8,
  parameter int BANK_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                narrow,
  input  logic [W-1:0]        x_val,
  input  logic [W-1:0]        y_val,
  input  logic                use_y,
  input  logic [W+BANK_W-1:0] base,
  input  logic [BANK_W-1:0]   src_bank,
  input  logic [BANK_W-1:0]   dst_bank,
  output logic [W+BANK_W-1:0] ea,
  output logic [W+BANK_W-1:0] src,
  output logic [W+BANK_W-1:0] dst
);
  localparam int AW = W + BANK_W;
  localparam logic [W-1:0] LO_MASK = W'((1 << HALF) - 1);

  logic [W-1:0] x_eff, y_eff, idx;
  assign x_eff = narrow ? (x_val & LO_MASK) : x_val;
  assign y_eff = narrow ? (y_val & LO_MASK) : y_val;
  assign idx   = use_y ? y_eff : x_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      ea  <= '0;
      src <= '0;
      dst <= '0;
    end else begin
      ea  <= base + {{BANK_W{1'b0}}, idx};
      src <= {src_bank, x_eff};
      dst <= {dst_bank, y_eff};
    end
  end

  a_r8_src_bank: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (src[AW-1:W] == $past(src_bank)));
  a_r9_dst_bank: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (dst[AW-1:W] == $past(dst_bank)));
endmodule

// File: rtl/mode_regfile.sv
module mode_regfile #(
  parameter int W      = 16,
  parameter int HALF   = 8,
  parameter int BANK_W = 8,
  parameter int LVL_W  = 3,
  parameter int SEL_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [W-1:0]        wr_data,
  input  logic                st_wr_en,
  input  logic [W-1:0]        st_wr_data,
  input  logic [SEL_W-1:0]    rd_sel_a,
  input  logic [SEL_W-1:0]    rd_sel_b,
  output logic [W-1:0]        rd_data_a,
  output logic [W-1:0]        rd_data_b,
  input  logic                idx_use_y,
  input  logic [W+BANK_W-1:0] idx_base,
  output logic [W+BANK_W-1:0] ea_out,
  input  logic [BANK_W-1:0]   src_bank,
  input  logic [BANK_W-1:0]   dst_bank,
  output logic [W+BANK_W-1:0] blk_src,
  output logic [W+BANK_W-1:0] blk_dst
);
  import mrf_pkg::*;
  localparam int NGPR = 4;
  localparam logic [W-1:0] LO_MASK = W'((1 << HALF) - 1);

  logic [W-1:0] gq [NGPR];
  logic [W-1:0] st_q, sp_q, pc_q, dp_q;
  logic [BANK_W-1:0] pb_q, db_q;
  logic m_flag, x_flag, x_rise;

  mrf_status #(.W(W), .LVL_W(LVL_W)) u_status (
    .clk(clk), .rst(rst), .we(st_wr_en), .d(st_wr_data), .q(st_q),
    .m_flag(m_flag), .x_flag(x_flag), .x_rise(x_rise)
  );

  for (genvar i = 0; i < NGPR; i++) begin : g_gpr
    localparam bit IS_IDX = (i >= 2);
    mrf_wide_reg #(.W(W), .HALF(HALF), .CAN_CLEAR(IS_IDX)) u_reg (
      .clk(clk), .rst(rst),
      .we(wr_en && (wr_sel == SEL_W'(i))),
      .narrow(IS_IDX ? x_flag : m_flag),
      .clr_hi(IS_IDX ? x_rise : 1'b0),
      .d(wr_data), .q(gq[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0; pc_q <= '0; dp_q <= '0; pb_q <= '0; db_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_W'(SEL_SP): sp_q <= wr_data;
        SEL_W'(SEL_PC): pc_q <= wr_data;
        SEL_W'(SEL_DP): dp_q <= wr_data;
        SEL_W'(SEL_PB): pb_q <= wr_data[BANK_W-1:0];
        SEL_W'(SEL_DB): db_q <= wr_data[BANK_W-1:0];
        default: ;
      endcase
    end
  end

  function automatic logic [W-1:0] pick(input logic [SEL_W-1:0] s);
    case (s)
      SEL_W'(SEL_A):  return m_flag ? (gq[0] & LO_MASK) : gq[0];
      SEL_W'(SEL_B):  return m_flag ? (gq[1] & LO_MASK) : gq[1];
      SEL_W'(SEL_X):  return x_flag ? (gq[2] & LO_MASK) : gq[2];
      SEL_W'(SEL_Y):  return x_flag ? (gq[3] & LO_MASK) : gq[3];
      SEL_W'(SEL_SP): return sp_q;
      SEL_W'(SEL_PC): return pc_q;
      SEL_W'(SEL_DP): return dp_q;
      SEL_W'(SEL_PB): return {{(W-BANK_W){1'b0}}, pb_q};
      SEL_W'(SEL_DB): return {{(W-BANK_W){1'b0}}, db_q};
      SEL_W'(SEL_ST): return st_q;
      default:        return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_a <= '0;
      rd_data_b <= '0;
    end else begin
      rd_data_a <= pick(rd_sel_a);
      rd_data_b <= pick(rd_sel_b);
    end
  end

  mrf_addr_gen #(.W(W), .HALF(HALF), .BANK_W(BANK_W)) u_addr (
    .clk(clk), .rst(rst), .narrow(x_flag),
    .x_val(gq[2]), .y_val(gq[3]), .use_y(idx_use_y), .base(idx_base),
    .src_bank(src_bank), .dst_bank(dst_bank),
    .ea(ea_out), .src(blk_src), .dst(blk_dst)
  );

  // R2: narrow accumulator read has a zero high byte
  a_r2_narrow_read: assert property (@(posedge clk) disable iff (rst)
    (((rd_sel_a == SEL_W'(SEL_A)) || (rd_sel_a == SEL_W'(SEL_B))) && m_flag)
      |=> (rd_data_a[W-1:HALF] == '0));

  // R12: unused selects read zero
  a_r12_unused_sel: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_b > SEL_W'(SEL_ST)) |=> (rd_data_b == '0));
endmodule

// File: tb/test_mode_regfile.sv
`timescale 1ns/1ps
module test_mode_regfile;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst;
  logic        wr_en, st_wr_en, idx_use_y;
  logic [3:0]  wr_sel, rd_sel_a, rd_sel_b;
  logic [15:0] wr_data, st_wr_data, rd_data_a, rd_data_b;
  logic [23:0] idx_base, ea_out, blk_src, blk_dst;
  logic [7:0]  src_bank, dst_bank;

  mode_regfile i_mode_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b),
    .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .idx_use_y(idx_use_y), .idx_base(idx_base), .ea_out(ea_out),
    .src_bank(src_bank), .dst_bank(dst_bank),
    .blk_src(blk_src), .blk_dst(blk_dst)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] g [4];
  logic [15:0] m_sp, m_pc, m_dp, m_st;
  logic [7:0]  m_pb, m_db;
  logic [15:0] e_a, e_b;
  logic [23:0] e_ea, e_src, e_dst;
  string       t_a, t_b;

  function automatic logic [15:0] mread(input logic [3:0] s);
    logic nm = m_st[5];
    logic nx = m_st[4];
    case (s)
      0: return nm ? {8'h00, g[0][7:0]} : g[0];
      1: return nm ? {8'h00, g[1][7:0]} : g[1];
      2: return nx ? {8'h00, g[2][7:0]} : g[2];
      3: return nx ? {8'h00, g[3][7:0]} : g[3];
      4: return m_sp;
      5: return m_pc;
      6: return m_dp;
      7: return {8'h00, m_pb};
      8: return {8'h00, m_db};
      9: return m_st;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] s);
    if (s < 2) return "R2";
    if (s < 4) return "R4";
    if (s == 9) return "R6";
    if (s < 9) return "R10";
    return "R12";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (g[i]) g[i] = 16'h0;
      m_sp = 0; m_pc = 0; m_dp = 0; m_pb = 0; m_db = 0; m_st = 16'h0034;
      e_a = 0; e_b = 0; e_ea = 0; e_src = 0; e_dst = 0;
      t_a = "R1"; t_b = "R1";
    end else begin
      logic [15:0] xi, yi, ix;
      logic        rise;
      e_a = mread(rd_sel_a); t_a = tag_of(rd_sel_a);
      e_b = mread(rd_sel_b); t_b = tag_of(rd_sel_b);
      xi = m_st[4] ? {8'h00, g[2][7:0]} : g[2];
      yi = m_st[4] ? {8'h00, g[3][7:0]} : g[3];
      ix = idx_use_y ? yi : xi;
      e_ea  = idx_base + {8'h00, ix};
      e_src = {src_bank, xi};
      e_dst = {dst_bank, yi};
      rise = st_wr_en && !m_st[4] && st_wr_data[4];
      if (wr_en) begin
        case (wr_sel)
          0, 1: if (m_st[5]) g[wr_sel][7:0] = wr_data[7:0]; else g[wr_sel] = wr_data;
          2, 3: if (m_st[4]) g[wr_sel][7:0] = wr_data[7:0]; else g[wr_sel] = wr_data;
          4: m_sp = wr_data;
          5: m_pc = wr_data;
          6: m_dp = wr_data;
          7: m_pb = wr_data[7:0];
          8: m_db = wr_data[7:0];
          default: ;
        endcase
      end
      if (rise) begin
        g[2][15:8] = 8'h00;
        g[3][15:8] = 8'h00;
      end
      if (st_wr_en) m_st = st_wr_data & 16'h07FF;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(t_a, {16'h0, rd_data_a}, {16'h0, e_a});
      check(t_b, {16'h0, rd_data_b}, {16'h0, e_b});
      check("R7", {8'h0, ea_out}, {8'h0, e_ea});
      check("R8", {8'h0, blk_src}, {8'h0, e_src});
      check("R9", {8'h0, blk_dst}, {8'h0, e_dst});
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; st_wr_en = 0;
  endtask

  task automatic wr(input logic [3:0] s, input logic [15:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic st(input logic [15:0] d);
    st_wr_en = 1; st_wr_data = d; tick(); st_wr_en = 0;
  endtask

  task automatic rd_check(input string tag, input logic [3:0] s, input logic [15:0] exp);
    rd_sel_a = s; tick();
    check(tag, {16'h0, rd_data_a}, {16'h0, exp});
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; wr_en = 0; st_wr_en = 0; wr_sel = 0; wr_data = 0; st_wr_data = 0;
    rd_sel_a = 0; rd_sel_b = 0; idx_use_y = 0; idx_base = 0; src_bank = 0; dst_bank = 0;
    repeat (3) tick();
    // R1: reset values
    check("R1", {8'h0, ea_out}, 32'h0);
    check("R1", {16'h0, rd_data_a}, 32'h0);
    rst = 0;
    for (int k = 0; k < 10; k++) rd_check("R1", 4'(k), (k == 9) ? 16'h0034 : 16'h0000);

    // R3: narrow accumulator write keeps the high byte
    wr(0, 16'hBEEF);
    rd_check("R2", 0, 16'h00EF);
    st(16'h0014);
    wr(0, 16'h1234);
    st(16'h0034);
    wr(0, 16'hAB55);
    rd_check("R2", 0, 16'h0055);
    st(16'h0014);
    rd_check("R3", 0, 16'h1255);

    // R5: x rise clears the index high bytes
    st(16'h0004);
    wr(2, 16'hA1B2);
    wr(3, 16'hC3D4);
    st(16'h0014);
    st(16'h0004);
    rd_check("R5", 2, 16'h00B2);
    rd_check("R5", 3, 16'h00D4);

    // R11: index write in the same cycle as an x rise
    wr_en = 1; wr_sel = 2; wr_data = 16'h5566;
    st_wr_en = 1; st_wr_data = 16'h0014;
    tick(); idle();
    st(16'h0004);
    rd_check("R11", 2, 16'h0066);

    // R6: upper status bits dropped, select 9 write ignored
    st(16'hFFFF);
    rd_check("R6", 9, 16'h07FF);
    wr(9, 16'h0000);
    rd_check("R6", 9, 16'h07FF);
    // R12: unused select write ignored
    wr(12, 16'hFFFF);
    rd_check("R12", 12, 16'h0000);
    st(16'h0004);

    // R7: indexed address wraps at 24 bits, narrow index zero-extended
    wr(2, 16'hFF80);
    idx_base = 24'hFFFFF0; idx_use_y = 0; tick();
    check("R7", {8'h0, ea_out}, 32'h0000FF70);
    st(16'h0014);
    idx_base = 24'h100000; tick();
    check("R7", {8'h0, ea_out}, 32'h00100080);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      wr_en      = ($urandom % 2) == 0;
      wr_sel     = 4'($urandom);
      wr_data    = 16'($urandom);
      st_wr_en   = ($urandom % 12) == 0;
      st_wr_data = 16'($urandom);
      rd_sel_a   = 4'($urandom);
      rd_sel_b   = 4'($urandom);
      idx_use_y  = 1'($urandom);
      idx_base   = 24'($urandom);
      src_bank   = 8'($urandom);
      dst_bank   = 8'($urandom);
      tick();
    end
    idle();
    tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule